// File: doc/BRIEF.md
# Reset and Trap Priority Controller

This block sits beside a small processor core and decides, every clock, whether the core must restart, enter a trap handler, or may accept a maskable interrupt. Reset causes are external reset, power-on, brown-out, watchdog expiry, use of an uninitialized pointer register, and execution of an illegal opcode. When any of them is present, the block emits a one-cycle restart pulse and records the cause in a sticky register. Software clears that register one bit at a time.

Trap requests occupy the levels above every maskable level. Request index k maps to level 8+k. A single trap is taken only when its level exceeds the core's current level, so a higher trap can preempt a running handler. Two or more simultaneous requests are treated as unrecoverable and force a restart. On entry, the outgoing level is pushed onto a small stack. A return strobe pops it and hands it back to the core. The vector slot address and a software-loaded handler target are presented with each trap strobe.

All event outputs are single-cycle strobes registered one clock after their cause. They carry no back-pressure: the core must act on them in the cycle they appear. The vector-table write port and the cause-clear port are plain register writes, not streams.

Top module: `rst_trap_ctrl`

## Requirements
- R1: Each of ext_rst_i, por_i, bor_i, wdt_to_i and uninit_ptr_i produces rst_o high for exactly one cycle, in the cycle after it is sampled.
- R2: illegal_op_i with flush_i low causes a restart and sets cause bit 5. With flush_i high it causes neither a restart nor a cause bit.
- R3: Two or more trap_req_i bits high in the same cycle give a restart next cycle, set cause bit 6, and take no trap.
- R4: A single request on bit k with level 8+k greater than cpu_ipl_i gives, next cycle, trap_take_o=1, trap_idx_o=k, ipl_wr_o=1 and ipl_o=8+k. Bit 3 of ipl_o is therefore always set on trap entry.
- R5: A single request whose level 8+k is not above cpu_ipl_i is not taken.
- R6: On trap entry, trap_vaddr_o equals VEC_BASE+2k, and trap_target_o equals the value last written to table entry k through vec_wr_i/vec_sel_i/vec_data_i.
- R7: cause_o holds one sticky bit per cause, with this bit map: 0 power-on, 1 external, 2 brown-out, 3 watchdog, 4 uninitialized pointer, 5 illegal opcode, 6 lockout. Writing 1 on cause_clr_i clears a bit. A set in the same cycle wins over the clear.
- R8: A power-on event, and the hardware reset rst_n, leave cause_o equal to only bit 0, whatever else is asserted.
- R9: trap_ret_i restores levels in last-in first-out order: the next cycle shows ipl_wr_o=1 with ipl_o equal to the saved level. A return with nothing saved gives no write.
- R10: irq_accept_o is high, in the same cycle, only when irq_req_i is high, irq_lvl_i is greater than cpu_ipl_i and no trap_req_i bit is set. Level 7 therefore blocks every maskable request.
- R11: A reset cause overrides any trap in the same cycle. A restart also discards all saved levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ext_rst_i | input | 1 | External restart request |
| por_i | input | 1 | Power-on event |
| bor_i | input | 1 | Supply-dip event |
| wdt_to_i | input | 1 | Watchdog expiry |
| uninit_ptr_i | input | 1 | Uninitialized pointer register used |
| illegal_op_i | input | 1 | Illegal opcode reached execution stage |
| flush_i | input | 1 | Current instruction flushed by a flow change |
| trap_req_i | input | N_TRAP | Trap requests, index k means level 8+k |
| cpu_ipl_i | input | LVL_W | Core's current priority level |
| trap_ret_i | input | 1 | Return from trap handler |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_lvl_i | input | LVL_W-1 | Maskable request level |
| cause_clr_i | input | 7 | Write-1-to-clear mask for cause_o |
| vec_wr_i | input | 1 | Handler table write strobe |
| vec_sel_i | input | IDX_W | Handler table entry |
| vec_data_i | input | ADDR_W | Handler table data |
| rst_o | output | 1 | One-cycle restart pulse |
| cause_o | output | 7 | Sticky reset-cause bits |
| trap_take_o | output | 1 | Trap entry strobe |
| trap_idx_o | output | IDX_W | Index of taken trap |
| trap_vaddr_o | output | ADDR_W | Vector slot address |
| trap_target_o | output | ADDR_W | Handler target from table |
| ipl_wr_o | output | 1 | Load ipl_o into the core's level |
| ipl_o | output | LVL_W | New priority level |
| irq_accept_o | output | 1 | Maskable request accepted |

## Verification
The hardest case to reach is a return that follows a restart while a level is still saved. Only the effect of the discarded stack is visible at the ports. The stimulus takes a trap, fires an external restart before any return, and then issues a return, which must produce no level write. Nested entry is reached by having the bench play the core: it raises cpu_ipl_i to each granted level before presenting the next request. Lockout and the override of a trap by a reset are driven by presenting the competing inputs in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CAUSE_W   = 7;
  localparam int C_POR     = 0;
  localparam int C_EXT     = 1;
  localparam int C_BOR     = 2;
  localparam int C_WDT     = 3;
  localparam int C_UNINIT  = 4;
  localparam int C_ILLOP   = 5;
  localparam int C_LOCKOUT = 6;
endpackage

// File: rtl/rtc_cause_reg.sv
module rtc_cause_reg
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_set,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic [CAUSE_W-1:0] clr_vec,
  output logic [CAUSE_W-1:0] cause_q
);
  localparam logic [CAUSE_W-1:0] POR_ONLY = CAUSE_W'(1) << C_POR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause_q <= POR_ONLY;
    else if (por_set) cause_q <= POR_ONLY;
    else              cause_q <= (cause_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/rtc_trap_pick.sv
module rtc_trap_pick #(
  parameter int N_TRAP = 8,
  parameter int LVL_W  = 4,
  localparam int IDX_W = $clog2(N_TRAP)
) (
  input  logic [N_TRAP-1:0] req,
  input  logic [LVL_W-1:0]  cur_ipl,
  output logic              multi,
  output logic              go,
  output logic [IDX_W-1:0]  idx,
  output logic [LVL_W-1:0]  lvl
);
  localparam int BAND = 1 << (LVL_W - 1);

  always_comb begin
    idx = '0;
    for (int k = 0; k < N_TRAP; k++) begin
      if (req[k]) idx = IDX_W'(k);
    end
  end

  assign lvl   = LVL_W'(BAND) + LVL_W'(idx);
  assign multi = $countones(req) > 1;
  assign go    = ($countones(req) == 1) && (lvl > cur_ipl);
endmodule

// File: rtl/rtc_lvl_stack.sv
module rtc_lvl_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  push_val,
  input  logic          pop,
  output logic [W-1:0]  pop_val,
  output logic          empty,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic          full;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign wr_idx = IW'(cnt);
  assign rd_idx = IW'(cnt - CW'(1));
  assign pop_val = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full && !clear) mem[wr_idx] <= push_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (push && !full)    cnt <= cnt + CW'(1);
    else if (pop && !empty)    cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/rst_trap_ctrl.sv
module rst_trap_ctrl
  import rtc_pkg::*;
#(
  parameter int N_TRAP                = 8,
  parameter int LVL_W                 = 4,
  parameter int ADDR_W                = 24,
  parameter int STACK_D               = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'h000004,
  localparam int IDX_W                = $clog2(N_TRAP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_rst_i,
  input  logic               por_i,
  input  logic               bor_i,
  input  logic               wdt_to_i,
  input  logic               uninit_ptr_i,
  input  logic               illegal_op_i,
  input  logic               flush_i,
  input  logic [N_TRAP-1:0]  trap_req_i,
  input  logic [LVL_W-1:0]   cpu_ipl_i,
  input  logic               trap_ret_i,
  input  logic               irq_req_i,
  input  logic [LVL_W-2:0]   irq_lvl_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  input  logic               vec_wr_i,
  input  logic [IDX_W-1:0]   vec_sel_i,
  input  logic [ADDR_W-1:0]  vec_data_i,
  output logic               rst_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               trap_take_o,
  output logic [IDX_W-1:0]   trap_idx_o,
  output logic [ADDR_W-1:0]  trap_vaddr_o,
  output logic [ADDR_W-1:0]  trap_target_o,
  output logic               ipl_wr_o,
  output logic [LVL_W-1:0]   ipl_o,
  output logic               irq_accept_o
);
  localparam int CW = $clog2(STACK_D + 1);

  logic               multi, go, take, ret_ok, rst_src, stk_empty;
  logic [IDX_W-1:0]   pick_idx;
  logic [LVL_W-1:0]   pick_lvl, saved_lvl;
  logic [CAUSE_W-1:0] set_vec;
  logic [CW-1:0]      stk_cnt;
  logic [ADDR_W-1:0]  vtab [N_TRAP];

  rtc_trap_pick #(.N_TRAP(N_TRAP), .LVL_W(LVL_W)) u_pick (
    .req(trap_req_i), .cur_ipl(cpu_ipl_i), .multi(multi), .go(go),
    .idx(pick_idx), .lvl(pick_lvl)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[C_POR]     = por_i;
    set_vec[C_EXT]     = ext_rst_i;
    set_vec[C_BOR]     = bor_i;
    set_vec[C_WDT]     = wdt_to_i;
    set_vec[C_UNINIT]  = uninit_ptr_i;
    set_vec[C_ILLOP]   = illegal_op_i && !flush_i;
    set_vec[C_LOCKOUT] = multi;
  end

  assign rst_src = |set_vec;
  assign take    = go && !rst_src;
  assign ret_ok  = trap_ret_i && !take && !rst_src && !stk_empty;

  rtc_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .por_set(por_i), .set_vec(set_vec),
    .clr_vec(cause_clr_i), .cause_q(cause_o)
  );

  rtc_lvl_stack #(.DEPTH(STACK_D), .W(LVL_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(rst_src), .push(take),
    .push_val(cpu_ipl_i), .pop(ret_ok), .pop_val(saved_lvl),
    .empty(stk_empty), .cnt(stk_cnt)
  );

  generate
    for (genvar g = 0; g < N_TRAP; g++) begin : g_vtab
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    vtab[g] <= '0;
        else if (vec_wr_i && vec_sel_i == IDX_W'(g))   vtab[g] <= vec_data_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_o         <= 1'b0;
      trap_take_o   <= 1'b0;
      trap_idx_o    <= '0;
      trap_vaddr_o  <= '0;
      trap_target_o <= '0;
      ipl_wr_o      <= 1'b0;
      ipl_o         <= '0;
    end else begin
      rst_o       <= rst_src;
      trap_take_o <= take;
      ipl_wr_o    <= take || ret_ok;
      if (take) begin
        trap_idx_o    <= pick_idx;
        trap_vaddr_o  <= VEC_BASE + ADDR_W'({pick_idx, 1'b0});
        trap_target_o <= vtab[pick_idx];
        ipl_o         <= pick_lvl;
      end else if (ret_ok) begin
        ipl_o         <= saved_lvl;
      end
    end
  end

  assign irq_accept_o = irq_req_i && (LVL_W'(irq_lvl_i) > cpu_ipl_i) && (trap_req_i == '0);
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int N_TRAP  = 8,
  parameter int LVL_W   = 4,
  parameter int STACK_D = 8,
  localparam int CW     = $clog2(STACK_D + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rst_i,
  input logic              por_i,
  input logic              bor_i,
  input logic              wdt_to_i,
  input logic              uninit_ptr_i,
  input logic              illegal_op_i,
  input logic              flush_i,
  input logic [N_TRAP-1:0] trap_req_i,
  input logic [LVL_W-1:0]  cpu_ipl_i,
  input logic              rst_o,
  input logic [6:0]        cause_o,
  input logic              trap_take_o,
  input logic [LVL_W-1:0]  ipl_o,
  input logic              irq_accept_o,
  input logic [CW-1:0]     stk_cnt
);
  assert_ext_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> rst_o);

  assert_flushed_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_op_i && flush_i && !ext_rst_i && !por_i && !bor_i && !wdt_to_i &&
     !uninit_ptr_i && $countones(trap_req_i) < 2) |=> !rst_o);

  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(trap_req_i) > 1) |=> (rst_o && !trap_take_o && cause_o[6]));

  assert_trap_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take_o |-> ipl_o[LVL_W-1]);

  assert_nest_higher_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take_o |-> (ipl_o > $past(cpu_ipl_i)));

  assert_por_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (cause_o == 7'b0000001));

  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CW'(STACK_D));

  assert_level7_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ipl_i == LVL_W'(7)) |-> !irq_accept_o);

  assert_reset_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_o && trap_take_o));
endmodule

bind rst_trap_ctrl rtc_checker #(.N_TRAP(N_TRAP), .LVL_W(LVL_W), .STACK_D(STACK_D)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .por_i(por_i), .bor_i(bor_i),
  .wdt_to_i(wdt_to_i), .uninit_ptr_i(uninit_ptr_i), .illegal_op_i(illegal_op_i),
  .flush_i(flush_i), .trap_req_i(trap_req_i), .cpu_ipl_i(cpu_ipl_i), .rst_o(rst_o),
  .cause_o(cause_o), .trap_take_o(trap_take_o), .ipl_o(ipl_o),
  .irq_accept_o(irq_accept_o), .stk_cnt(stk_cnt)
);

// File: tb/rst_trap_ctrl_tb_top.sv
module rst_trap_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst_i = 0, por_i = 0, bor_i = 0, wdt_to_i = 0, uninit_ptr_i = 0;
  logic illegal_op_i = 0, flush_i = 0, trap_ret_i = 0, irq_req_i = 0, vec_wr_i = 0;
  logic [7:0]  trap_req_i = '0;
  logic [3:0]  cpu_ipl_i = '0;
  logic [2:0]  irq_lvl_i = '0;
  logic [6:0]  cause_clr_i = '0;
  logic [2:0]  vec_sel_i = '0;
  logic [23:0] vec_data_i = '0;
  logic        rst_o, trap_take_o, ipl_wr_o, irq_accept_o;
  logic [6:0]  cause_o;
  logic [2:0]  trap_idx_o;
  logic [23:0] trap_vaddr_o, trap_target_o;
  logic [3:0]  ipl_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    logic rst; logic take; logic [2:0] idx; logic iplwr; logic [3:0] ipl;
    logic [6:0] cause; logic [23:0] tgt; logic [23:0] va; string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  rst_trap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .por_i(por_i), .bor_i(bor_i),
    .wdt_to_i(wdt_to_i), .uninit_ptr_i(uninit_ptr_i), .illegal_op_i(illegal_op_i),
    .flush_i(flush_i), .trap_req_i(trap_req_i), .cpu_ipl_i(cpu_ipl_i),
    .trap_ret_i(trap_ret_i), .irq_req_i(irq_req_i), .irq_lvl_i(irq_lvl_i),
    .cause_clr_i(cause_clr_i), .vec_wr_i(vec_wr_i), .vec_sel_i(vec_sel_i),
    .vec_data_i(vec_data_i), .rst_o(rst_o), .cause_o(cause_o),
    .trap_take_o(trap_take_o), .trap_idx_o(trap_idx_o), .trap_vaddr_o(trap_vaddr_o),
    .trap_target_o(trap_target_o), .ipl_wr_o(ipl_wr_o), .ipl_o(ipl_o),
    .irq_accept_o(irq_accept_o)
  );

  function automatic exp_t mk(logic r, logic t, logic [2:0] i, logic w, logic [3:0] l,
                              logic [6:0] c, logic [23:0] g, logic [23:0] v, string s);
    exp_t e;
    e.rst = r; e.take = t; e.idx = i; e.iplwr = w; e.ipl = l;
    e.cause = c; e.tgt = g; e.va = v; e.tag = s;
    return e;
  endfunction

  // Driver: inputs already set at a falling edge; queue the expectation, let one edge pass.
  task automatic step(exp_t e);
    q.push_back(e);
    @(negedge clk);
    ext_rst_i = 0; por_i = 0; bor_i = 0; wdt_to_i = 0; uninit_ptr_i = 0;
    illegal_op_i = 0; flush_i = 0; trap_ret_i = 0; vec_wr_i = 0;
    trap_req_i = '0; cause_clr_i = '0;
  endtask

  // Monitor: compare registered outputs just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      checks++;
      bad = (rst_o !== e.rst) || (trap_take_o !== e.take) || (ipl_wr_o !== e.iplwr) ||
            (cause_o !== e.cause);
      if (e.iplwr && ipl_o !== e.ipl) bad = 1;
      if (e.take && (trap_idx_o !== e.idx || trap_target_o !== e.tgt || trap_vaddr_o !== e.va)) bad = 1;
      if (bad) begin
        fails++;
        $display("FAIL %s: got rst=%b take=%b idx=%0d wr=%b ipl=%0d cause=%h tgt=%h va=%h exp rst=%b take=%b idx=%0d wr=%b ipl=%0d cause=%h tgt=%h va=%h",
          e.tag, rst_o, trap_take_o, trap_idx_o, ipl_wr_o, ipl_o, cause_o, trap_target_o, trap_vaddr_o,
          e.rst, e.take, e.idx, e.iplwr, e.ipl, e.cause, e.tgt, e.va);
      end
    end
  end

  task automatic direct(bit ok, string tag, int got, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, got, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp under 5000", cycles);
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: hardware reset leaves only the power-on cause bit
    direct(cause_o == 7'h01, "R8 reset cause", cause_o, 1);
    direct(!rst_o && !trap_take_o && !ipl_wr_o, "R1 reset outputs idle", rst_o, 0);

    // R6: load handler table
    for (int k = 0; k < 8; k++) begin
      vec_wr_i = 1; vec_sel_i = 3'(k); vec_data_i = 24'h000200 + 24'(k * 16);
      step(mk(0, 0, 0, 0, 0, 7'h01, 0, 0, "R6 table load"));
    end

    // R7: write-1-to-clear
    cause_clr_i = 7'h01; step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R7 clear por bit"));

    // R1: each source gives a one-cycle pulse and its cause bit
    ext_rst_i = 1;    step(mk(1, 0, 0, 0, 0, 7'h02, 0, 0, "R1 external"));
    step(mk(0, 0, 0, 0, 0, 7'h02, 0, 0, "R1 single cycle pulse"));
    bor_i = 1;        step(mk(1, 0, 0, 0, 0, 7'h06, 0, 0, "R1 brown-out"));
    wdt_to_i = 1;     step(mk(1, 0, 0, 0, 0, 7'h0E, 0, 0, "R1 watchdog"));
    uninit_ptr_i = 1; step(mk(1, 0, 0, 0, 0, 7'h1E, 0, 0, "R1 uninit pointer"));
    cause_clr_i = 7'h7F; step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R7 clear all"));

    // R2: flushed illegal opcode has no effect; executed one restarts
    illegal_op_i = 1; flush_i = 1; step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R2 flushed illegal"));
    illegal_op_i = 1;              step(mk(1, 0, 0, 0, 0, 7'h20, 0, 0, "R2 executed illegal"));
    cause_clr_i = 7'h20;           step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R7 clear illegal"));

    // R4/R6: trap 2 from level 3
    cpu_ipl_i = 4'd3; trap_req_i = 8'b0000_0100;
    step(mk(0, 1, 2, 1, 4'd10, 7'h00, 24'h000220, 24'h000008, "R4 R6 trap 2 entry"));
    // nested: core now at 10, trap 5 preempts
    cpu_ipl_i = 4'd10; trap_req_i = 8'b0010_0000;
    step(mk(0, 1, 5, 1, 4'd13, 7'h00, 24'h000250, 24'h00000E, "R4 nested trap 5"));
    // R5: trap 1 (level 9) below level 13 not taken
    cpu_ipl_i = 4'd13; trap_req_i = 8'b0000_0010;
    step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R5 lower trap held off"));
    // R9: pops in LIFO order, then empty gives nothing
    trap_ret_i = 1; step(mk(0, 0, 0, 1, 4'd10, 7'h00, 0, 0, "R9 return to 10"));
    cpu_ipl_i = 4'd10;
    trap_ret_i = 1; step(mk(0, 0, 0, 1, 4'd3, 7'h00, 0, 0, "R9 return to 3"));
    cpu_ipl_i = 4'd3;
    trap_ret_i = 1; step(mk(0, 0, 0, 0, 0, 7'h00, 0, 0, "R9 empty return"));

    // R3: lockout on two simultaneous traps
    trap_req_i = 8'b0000_0011; step(mk(1, 0, 0, 0, 0, 7'h40, 0, 0, "R3 lockout"));

    // R11: restart discards saved levels
    cpu_ipl_i = 4'd0; trap_req_i = 8'b0000_0001;
    step(mk(0, 1, 0, 1, 4'd8, 7'h40, 24'h000200, 24'h000004, "R4 trap 0 entry"));
    ext_rst_i = 1;  step(mk(1, 0, 0, 0, 0, 7'h42, 0, 0, "R11 restart after entry"));
    trap_ret_i = 1; step(mk(0, 0, 0, 0, 0, 7'h42, 0, 0, "R11 stack emptied"));
    // R11: reset cause overrides trap in the same cycle
    wdt_to_i = 1; trap_req_i = 8'b0000_1000;
    step(mk(1, 0, 0, 0, 0, 7'h4A, 0, 0, "R11 reset over trap"));
    // R7: set wins over clear
    wdt_to_i = 1; cause_clr_i = 7'h08;
    step(mk(1, 0, 0, 0, 0, 7'h4A, 0, 0, "R7 set beats clear"));
    // R8: power-on with brown-out leaves only bit 0
    por_i = 1; bor_i = 1;
    step(mk(1, 0, 0, 0, 0, 7'h01, 0, 0, "R8 power-on clears others"));
    step(mk(0, 0, 0, 0, 0, 7'h01, 0, 0, "R8 idle after power-on"));

    // R10: maskable acceptance, checked combinationally between edges
    irq_req_i = 1; cpu_ipl_i = 4'd7; irq_lvl_i = 3'd7; #1;
    direct(irq_accept_o == 0, "R10 level 7 blocks", irq_accept_o, 0);
    cpu_ipl_i = 4'd4; irq_lvl_i = 3'd5; #1;
    direct(irq_accept_o == 1, "R10 higher accepted", irq_accept_o, 1);
    irq_lvl_i = 3'd4; #1;
    direct(irq_accept_o == 0, "R10 equal rejected", irq_accept_o, 0);
    irq_lvl_i = 3'd6; trap_req_i = 8'b1000_0000; #1;
    direct(irq_accept_o == 0, "R10 trap pending blocks", irq_accept_o, 0);
    trap_req_i = '0; irq_req_i = 0; #1;

    @(negedge clk);
    @(negedge clk);
    direct(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule